// File: doc/BRIEF.md
# Quarter-Table Direct Digital Synthesis Core

This core turns a fixed reference clock into a digitally tuned periodic waveform. A 28-bit phase register advances by a programmable tuning word on every enabled clock, so the output frequency is `tune_word * f_clk / 2^28`. The top 12 bits of that phase, plus a 12-bit phase offset, form the instantaneous phase that is mapped to a signed amplitude.

The sine is rebuilt from a table that stores only the first quarter of a cycle. The second-highest phase bit mirrors the table index, and the highest phase bit flips the sign. The same phase path also feeds a triangle generator and a square generator. The waveform is picked per sample by `wave_sel`. The samples form a stream that is qualified by `sample_valid` and has no back-pressure. Every cycle with `sample_valid` high carries a new sample, and the consumer must take it in that cycle. In cycles without a valid sample, `sample` holds its last value.

Top module: `dds_quarter_core`

## Requirements
- R1: On each rising clock edge with `en` high, the internal phase becomes (phase + `tune_word`) modulo 2^28. With `en` low it is unchanged.
- R2: The waveform repeats every 2^28 / `tune_word` enabled samples. For example, `tune_word` = 2^26 gives a period of four samples.
- R3: A new `tune_word` takes effect on the next enabled edge. The phase is not cleared, so the waveform stays continuous.
- R4: The sample phase is p = (phase[27:16] + `phase_ofs`) modulo 4096. An offset of 0 leaves the phase unchanged.
- R5: Phase bits 15..0 never affect the sample. With `tune_word` = 1 the sample stays constant for 2^16 enabled cycles.
- R6: When `wave_sel` is 0 or 3 (sine), `sample` is within 1 of round(2047·sin(2π(p+0.5)/4096)). For p < 2048 it is never negative.
- R7: When `wave_sel` is 1 (triangle), `sample` = 2u − 2047, where u = p for p < 2048 and u = 4095 − p otherwise.
- R8: When `wave_sel` is 2 (square), `sample` is +2047 for p < 2048 and −2047 otherwise.
- R9: `en`, `tune_word`, `phase_ofs` and `wave_sel` are sampled together at an edge. Their result appears after the third edge counted from that edge, with `sample_valid` equal to the `en` of that edge. While `sample_valid` is low, `sample` keeps its previous value.
- R10: Synchronous reset clears the phase, `sample_valid` and `sample` to 0. The first sample after reset uses phase 0 plus the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the phase and emit a sample |
| tune_word | input | 28 | Phase increment per enabled clock |
| phase_ofs | input | 12 | Phase offset added to the truncated phase |
| wave_sel | input | 2 | 0 sine, 1 triangle, 2 square, 3 sine |
| sample_valid | output | 1 | A new sample is on `sample` |
| sample | output | 12 | Signed two's-complement amplitude |

## Verification
The quadrant boundaries are the hardest cases to reach. These are the mirrored index at p = 1023/1024 and the sign flip at p = 2047/2048, and they must be reached in every waveform mode. Random tuning words reach them only rarely. The stimulus therefore uses a tuning word of exactly 2^16, which steps p by one per sample, and runs more than 4096 samples so that every table address is visited going up and coming back down. A Nyquist-rate word, offset changes in mid-stream and an `en` pattern with gaps then exercise the wrap, the phase offset and the three-stage alignment.

// File: rtl/dds_pkg.sv
package dds_pkg;

  typedef enum logic [1:0] {
    WAVE_SINE   = 2'd0,
    WAVE_TRI    = 2'd1,
    WAVE_SQUARE = 2'd2,
    WAVE_SINE2  = 2'd3
  } wave_t;

  // pi scaled by 2^30
  localparam longint PI_Q30 = 64'sd3373259426;

  // Magnitude of sin(pi/2 * (idx + 0.5) / 2^qbits) scaled to amax, rounded.
  // Fixed-point Taylor series, evaluated at elaboration.
  function automatic int quarter_sine_mag(int idx, int qbits, int amax);
    longint x, x2, term, acc;
    int r;
    x    = (longint'(2 * idx + 1) * PI_Q30) >>> (qbits + 2);
    x2   = (x * x) >>> 30;
    term = x;
    acc  = x;
    for (int k = 1; k <= 5; k++) begin
      term = -(((term * x2) >>> 30) / longint'((2 * k) * (2 * k + 1)));
      acc  = acc + term;
    end
    r = int'((acc * longint'(amax) + (64'sd1 <<< 29)) >>> 30);
    if (r > amax) r = amax;
    if (r < 0) r = 0;
    return r;
  endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [ACC_W-1:0] tune_word,
  input  logic [PH_W-1:0]  phase_ofs,
  input  dds_pkg::wave_t   wave_i,
  output logic             v_o,
  output logic [PH_W-1:0]  ph_o,
  output logic [PH_W-1:0]  ofs_o,
  output dds_pkg::wave_t   wave_o
);
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      v_o    <= 1'b0;
      ph_o   <= '0;
      ofs_o  <= '0;
      wave_o <= dds_pkg::WAVE_SINE;
    end else begin
      v_o    <= en;
      ph_o   <= acc_q[ACC_W-1 -: PH_W];
      ofs_o  <= phase_ofs;
      wave_o <= wave_i;
      if (en) acc_q <= acc_q + tune_word;
    end
  end

  // R1
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc_q));

endmodule

// File: rtl/dds_offset_add.sv
module dds_offset_add #(
  parameter int PH_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            v_i,
  input  logic [PH_W-1:0] ph_i,
  input  logic [PH_W-1:0] ofs_i,
  input  dds_pkg::wave_t  wave_i,
  output logic            v_o,
  output logic [PH_W-1:0] ph_o,
  output dds_pkg::wave_t  wave_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      v_o    <= 1'b0;
      ph_o   <= '0;
      wave_o <= dds_pkg::WAVE_SINE;
    end else begin
      v_o    <= v_i;
      ph_o   <= ph_i + ofs_i;
      wave_o <= wave_i;
    end
  end

  // R9
  valid_chain_chk: assert property (@(posedge clk) disable iff (rst)
    v_o |-> $past(v_i));

  // R4
  zero_ofs_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(v_i) && $past(ofs_i) == '0) |-> ph_o == $past(ph_i));

endmodule

// File: rtl/dds_amp_map.sv
module dds_amp_map #(
  parameter int PH_W = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   v_i,
  input  logic [PH_W-1:0]        ph_i,
  input  dds_pkg::wave_t         wave_i,
  output logic                   v_o,
  output logic signed [PH_W-1:0] amp_o
);
  localparam int AMP_W  = PH_W;
  localparam int MAG_W  = AMP_W - 1;
  localparam int IDX_W  = PH_W - 2;
  localparam int QDEPTH = 1 << IDX_W;
  localparam int AMAX   = (1 << (AMP_W - 1)) - 1;

  logic [MAG_W-1:0] rom [QDEPTH];

  for (genvar g = 0; g < QDEPTH; g++) begin : g_rom
    assign rom[g] = MAG_W'(dds_pkg::quarter_sine_mag(g, IDX_W, AMAX));
  end

  logic [IDX_W-1:0]        idx;
  logic [MAG_W-1:0]        mag;
  logic signed [AMP_W-1:0] sine_v;
  logic [PH_W-2:0]         fold;
  logic signed [AMP_W:0]   tri_w;
  logic signed [AMP_W-1:0] sq_v;
  logic signed [AMP_W-1:0] next_amp;

  always_comb begin
    idx    = ph_i[PH_W-2] ? ~ph_i[IDX_W-1:0] : ph_i[IDX_W-1:0];
    mag    = rom[idx];
    sine_v = ph_i[PH_W-1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    fold   = ph_i[PH_W-1] ? ~ph_i[PH_W-2:0] : ph_i[PH_W-2:0];
    tri_w  = $signed({1'b0, fold, 1'b0}) - $signed((AMP_W + 1)'(AMAX));
    sq_v   = ph_i[PH_W-1] ? -$signed(AMP_W'(AMAX)) : $signed(AMP_W'(AMAX));
    unique case (wave_i)
      dds_pkg::WAVE_TRI:    next_amp = tri_w[AMP_W-1:0];
      dds_pkg::WAVE_SQUARE: next_amp = sq_v;
      default:              next_amp = sine_v;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_o   <= 1'b0;
      amp_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) amp_o <= next_amp;
    end
  end

  // R8
  square_level_chk: assert property (@(posedge clk) disable iff (rst)
    (v_i && wave_i == dds_pkg::WAVE_SQUARE) |=>
      (amp_o == $signed(AMP_W'(AMAX)) || amp_o == -$signed(AMP_W'(AMAX))));

  // R6
  sine_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (v_i && wave_i == dds_pkg::WAVE_SINE && !ph_i[PH_W-1]) |=> !amp_o[AMP_W-1]);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !v_i |=> $stable(amp_o));

endmodule

// File: rtl/dds_quarter_core.sv
module dds_quarter_core #(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic [ACC_W-1:0]       tune_word,
  input  logic [PH_W-1:0]        phase_ofs,
  input  logic [1:0]             wave_sel,
  output logic                   sample_valid,
  output logic signed [PH_W-1:0] sample
);
  logic            s1_v, s2_v;
  logic [PH_W-1:0] s1_ph, s1_ofs, s2_ph;
  dds_pkg::wave_t  s1_wave, s2_wave;

  dds_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
    .clk(clk), .rst(rst), .en(en), .tune_word(tune_word),
    .phase_ofs(phase_ofs), .wave_i(dds_pkg::wave_t'(wave_sel)),
    .v_o(s1_v), .ph_o(s1_ph), .ofs_o(s1_ofs), .wave_o(s1_wave)
  );

  dds_offset_add #(.PH_W(PH_W)) u_ofs (
    .clk(clk), .rst(rst), .v_i(s1_v), .ph_i(s1_ph), .ofs_i(s1_ofs),
    .wave_i(s1_wave), .v_o(s2_v), .ph_o(s2_ph), .wave_o(s2_wave)
  );

  dds_amp_map #(.PH_W(PH_W)) u_map (
    .clk(clk), .rst(rst), .v_i(s2_v), .ph_i(s2_ph), .wave_i(s2_wave),
    .v_o(sample_valid), .amp_o(sample)
  );

  // R9
  out_valid_chk: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> $past(s2_v));

endmodule

// File: tb/dds_quarter_core_test.sv
module dds_quarter_core_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [27:0] tune_word = '0;
  logic [11:0] phase_ofs = '0;
  logic [1:0]  wave_sel = 2'd0;
  logic        sample_valid;
  logic signed [11:0] sample;

  always #5 clk = ~clk;

  dds_quarter_core uut (
    .clk(clk), .rst(rst), .en(en), .tune_word(tune_word),
    .phase_ofs(phase_ofs), .wave_sel(wave_sel),
    .sample_valid(sample_valid), .sample(sample)
  );

  int n_checks = 0;
  int n_fail = 0;
  string tag = "R10";
  bit started = 0;
  bit done = 0;

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int wave_value(int p, int md);
    real x;
    int u;
    case (md)
      1: begin
        u = (p < 2048) ? p : 4095 - p;
        return 2 * u - 2047;
      end
      2: return (p < 2048) ? 2047 : -2047;
      default: begin
        x = 2047.0 * $sin(2.0 * 3.14159265358979 * (p + 0.5) / 4096.0);
        return $rtoi(x >= 0.0 ? x + 0.5 : x - 0.5);
      end
    endcase
  endfunction

  typedef struct {bit v; int ph; int md;} ent_t;
  ent_t q[$];
  longint macc = 0;
  bit exp_v = 0;
  int exp_s = 0;
  int exp_tol = 0;

  // behavioural reference: advance at every edge
  always @(posedge clk) begin
    ent_t e, o;
    started = 1;
    if (rst) begin
      macc = 0;
      q.delete();
      exp_v = 0;
      exp_s = 0;
      exp_tol = 0;
    end else begin
      e.v = en;
      e.ph = int'(((macc >> 16) + longint'(phase_ofs)) % 4096);
      e.md = int'(wave_sel);
      if (en) macc = (macc + longint'(tune_word)) % (64'd1 << 28);
      q.push_back(e);
      if (q.size() == 3) begin
        o = q.pop_front();
        exp_v = o.v;
        if (o.v) begin
          exp_s = wave_value(o.ph, o.md);
          exp_tol = (o.md == 1 || o.md == 2) ? 0 : 1;
        end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    int d;
    if (started && !done) begin
      check(sample_valid == exp_v, {tag, " R9 valid"}, int'(sample_valid), int'(exp_v));
      d = int'(sample) - exp_s;
      check(d <= exp_tol && d >= -exp_tol, {tag, " sample"}, int'(sample), exp_s);
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    run(4);
    // R10: reset state
    tag = "R10";
    check(sample_valid == 1'b0, "R10 reset valid", int'(sample_valid), 0);
    check(sample == 0, "R10 reset sample", int'(sample), 0);
    rst = 1'b0;
    // R2: period of four samples
    tag = "R2";
    tune_word = 28'h4000000; en = 1'b1; wave_sel = 2'd0;
    run(24);
    // R5: low phase bits ignored
    rst = 1'b1; run(3); rst = 1'b0;
    tag = "R5";
    tune_word = 28'd1;
    run(40);
    // R6: full sine sweep, one phase step per sample
    tag = "R6";
    tune_word = 28'h0010000;
    run(4200);
    wave_sel = 2'd3;
    run(300);
    // R7: triangle
    tag = "R7"; wave_sel = 2'd1; tune_word = 28'h0030000;
    run(1500);
    // R8: square
    tag = "R8"; wave_sel = 2'd2; tune_word = 28'h0250000;
    run(400);
    // R4: offsets changed mid-stream
    tag = "R4"; wave_sel = 2'd0; tune_word = 28'h0070000;
    phase_ofs = 12'h400; run(50);
    phase_ofs = 12'hFFF; run(50);
    wave_sel = 2'd1; phase_ofs = 12'h801; run(50);
    phase_ofs = 12'h000;
    // R3: tuning word change without phase reset
    tag = "R3"; wave_sel = 2'd0;
    tune_word = 28'h0123456; run(37);
    tune_word = 28'h0ABCDEF; run(37);
    tune_word = 28'h0000F00; run(20);
    // R9: gaps in enable
    tag = "R9"; tune_word = 28'h0090000;
    for (int i = 0; i < 60; i++) begin
      en = (i % 3 != 1) && (i % 7 != 0);
      wave_sel = 2'(i % 4);
      run(1);
    end
    en = 1'b1;
    // R1: Nyquist word and wrap
    tag = "R1"; wave_sel = 2'd1; tune_word = 28'h7FFFFFF;
    run(40);
    tune_word = 28'hFFFFFFF; wave_sel = 2'd0; run(40);
    // R10: reset mid-run, first sample at phase 0 plus offset
    rst = 1'b1; run(2);
    tag = "R10"; phase_ofs = 12'h200; wave_sel = 2'd2; rst = 1'b0;
    tune_word = 28'h0100000; run(30);
    en = 1'b0; run(6);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(10 * 150000);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule